// File: doc/BRIEF.md
# Periodic ADC Threshold Wake Monitor

This block runs background conversions on up to two slots without any software involvement. Each slot has its own enable and its own 4-bit channel number. A programmable interval timer starts each round. In a round, every enabled slot sends one request to an external ADC core and waits for the result. The 12-bit result is compared with that slot's limit. A per-slot polarity bit sets the direction of the compare: the limit is either a ceiling or a floor. When a result crosses its limit, a sticky interrupt for that slot is set. The crossing also starts the safe shutdown sequence on its own.

The shutdown sequence keeps the conversion engine forced on while both slot enables are cleared. It then holds the force for a fixed wait of `WAIT_US` microseconds, counted in clock cycles from `CLK_MHZ`, and then releases it. Software can start the same sequence with a stop command. The `available` output is high only when no conversion is in flight and the engine is not forced on.

Configuration uses a simple byte write port. Address 0 is the control byte: bit 0 enables slot 0, bit 1 enables slot 1, and bit 2 is the stop command. Address 1 is the period code. Address 2 packs both channel numbers. Addresses 3/4 hold the slot 0 limit and addresses 5/6 hold the slot 1 limit. Address 7 clears interrupts: writing a 1 to a bit clears that slot's interrupt.

The conversion state machine has three states:
- `CV_IDLE`: waits for a timer tick while shutdown is not active. It then goes to `CV_SLOT0` if slot 0 is enabled, or else to `CV_SLOT1` if slot 1 is enabled.
- `CV_SLOT0`: on acknowledge, goes to `CV_SLOT1` when slot 1 is enabled, no crossing occurred and shutdown is idle. Otherwise it returns to `CV_IDLE`.
- `CV_SLOT1`: returns to `CV_IDLE` on acknowledge.

The shutdown state machine steps through four states:
- `SD_IDLE` goes to `SD_FORCE` when a crossing or a stop command occurs.
- `SD_FORCE` moves to `SD_CLEAR` unconditionally.
- `SD_CLEAR` clears both enables and moves to `SD_HOLD`.
- `SD_HOLD` counts `CLK_MHZ*WAIT_US` cycles and then returns to `SD_IDLE`.

Top module: `auto_thresh_monitor`

## Requirements
- R1: After reset, `adc_req` is 0, both interrupts are 0 and `available` is 1.
- R2: While at least one slot is enabled, a round starts every `BASE_CYCLES << code` cycles, where `code` is the 4-bit value written at address 1. The first request appears `BASE_CYCLES << code` cycles after the enabling write.
- R3: Within a round, slot 0 converts before slot 1. Slot 0 uses channel byte bits [3:0] and slot 1 uses bits [7:4]. `adc_req` and `adc_chan` hold steady until `adc_ack`.
- R4: With polarity 0, a result strictly greater than the limit sets that slot's interrupt. A result equal to the limit does not.
- R5: With polarity 1, a result strictly less than the limit sets that slot's interrupt.
- R6: Each interrupt stays set until software writes a 1 to its bit at address 7 (bit 0 for slot 0, bit 1 for slot 1). Such a write does not affect the other slot's interrupt.
- R7: A crossing starts the shutdown sequence. The engine is forced on and both enables are cleared. After the wait the force is released, and no further conversions start.
- R8: Writing the control byte with bit 2 set runs the same shutdown sequence and leaves the enables unchanged until the sequence clears them.
- R9: `available` is 1 exactly when no conversion is in flight and the shutdown sequence is idle.
- R10: A crossing on slot 0 ends the round; slot 1 is not converted in that round.
- R11: A limit is written as a low byte (address 3 or 5) plus a high byte (address 4 or 6). Bits [3:0] of the high byte are limit bits 11:8, and bit 7 is the polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| adc_req | output | 1 | Conversion request, held until acknowledge |
| adc_chan | output | 4 | Channel to convert |
| adc_ack | input | 1 | One-cycle result valid from the ADC core |
| adc_result | input | 12 | Conversion result |
| irq_slot0 | output | 1 | Sticky crossing interrupt for slot 0 |
| irq_slot1 | output | 1 | Sticky crossing interrupt for slot 1 |
| available | output | 1 | Engine idle and not forced on |

## Verification
The assertions make three assumptions about the inputs:
- `adc_ack` is a single-cycle pulse given only while a request is pending.
- The channel-select byte is not rewritten while a conversion is in flight.
- `BASE_CYCLES` is at least 2.

The bench's ADC responder follows these rules: it acknowledges each request once, after a fixed latency, and only then looks for the next request. All configuration writes happen between rounds or while the slots are disabled. The crossing cases include a result exactly equal to the limit, and a stop command that may land in the middle of a round.

// File: rtl/atm_pkg.sv
`timescale 1ns/1ps
package atm_pkg;
    localparam int NUM_SLOTS = 2;
    localparam int CHAN_W    = 4;
    localparam int RES_W     = 12;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_PERIOD = 3'd1;
    localparam logic [2:0] ADDR_CHSEL  = 3'd2;
    localparam int         ADDR_LIM_BASE = 3;
    localparam logic [2:0] ADDR_IRQCLR = 3'd7;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [RES_W-1:0]  limit;
        logic              below;
    } slot_cfg_t;

    typedef enum logic [1:0] {CV_IDLE, CV_SLOT0, CV_SLOT1} conv_state_e;
    typedef enum logic [1:0] {SD_IDLE, SD_FORCE, SD_CLEAR, SD_HOLD} sd_state_e;

    function automatic logic crossed(input logic [RES_W-1:0] res, input slot_cfg_t c);
        return c.below ? (res < c.limit) : (res > c.limit);
    endfunction
endpackage

// File: rtl/atm_cfg_regs.sv
`timescale 1ns/1ps
module atm_cfg_regs import atm_pkg::*; #(
    parameter int CODE_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [2:0]                      addr,
    input  logic [7:0]                      wdata,
    input  logic                            clr_en,
    output logic [NUM_SLOTS-1:0]            en,
    output logic [CODE_W-1:0]               code,
    output slot_cfg_t [NUM_SLOTS-1:0]       cfg,
    output logic [NUM_SLOTS-1:0]            irq_clr,
    output logic                            stop_req
);
    logic [7:0] chsel_q;

    assign stop_req = we && (addr == ADDR_CTRL) && wdata[2];
    assign irq_clr  = (we && (addr == ADDR_IRQCLR)) ? wdata[NUM_SLOTS-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en      <= '0;
            code    <= '0;
            chsel_q <= '0;
        end else begin
            if (clr_en)
                en <= '0;
            else if (we && addr == ADDR_CTRL && !wdata[2])
                en <= wdata[NUM_SLOTS-1:0];
            if (we && addr == ADDR_PERIOD)
                code <= wdata[CODE_W-1:0];
            if (we && addr == ADDR_CHSEL)
                chsel_q <= wdata;
        end
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam logic [2:0] A_LO = 3'(ADDR_LIM_BASE + 2*i);
        localparam logic [2:0] A_HI = 3'(ADDR_LIM_BASE + 2*i + 1);
        logic [RES_W-1:0] lim_q;
        logic             pol_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lim_q <= '0;
                pol_q <= 1'b0;
            end else if (we && addr == A_LO) begin
                lim_q[7:0] <= wdata;
            end else if (we && addr == A_HI) begin
                lim_q[RES_W-1:8] <= wdata[RES_W-9:0];
                pol_q            <= wdata[7];
            end
        end
        assign cfg[i].chan  = chsel_q[CHAN_W*i +: CHAN_W];
        assign cfg[i].limit = lim_q;
        assign cfg[i].below = pol_q;
    end

    assert_enables_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (en == '0));
endmodule

// File: rtl/atm_period_timer.sv
`timescale 1ns/1ps
module atm_period_timer #(
    parameter int BASE_CYCLES = 64,
    parameter int CODE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int CNT_W = $clog2(BASE_CYCLES) + (1 << CODE_W) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = (CNT_W'(BASE_CYCLES) << code) - 1'b1;
    assign tick  = run && (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/atm_shutdown_seq.sv
`timescale 1ns/1ps
module atm_shutdown_seq import atm_pkg::*; #(
    parameter int WAIT_CYCLES = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic force_on,
    output logic clr_en
);
    localparam int WCNT_W = $clog2(WAIT_CYCLES + 1);

    sd_state_e          st, nxt;
    logic [WCNT_W-1:0]  cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SD_IDLE;
            cnt <= '0;
        end else begin
            st <= nxt;
            if (st == SD_CLEAR)
                cnt <= '0;
            else if (st == SD_HOLD)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            SD_IDLE:  if (start) nxt = SD_FORCE;
            SD_FORCE: nxt = SD_CLEAR;
            SD_CLEAR: nxt = SD_HOLD;
            SD_HOLD:  if (cnt == WCNT_W'(WAIT_CYCLES - 1)) nxt = SD_IDLE;
            default:  nxt = SD_IDLE;
        endcase
    end

    always_comb begin
        force_on = (st != SD_IDLE);
        clr_en   = (st == SD_CLEAR);
    end
endmodule

// File: rtl/atm_conv_seq.sv
`timescale 1ns/1ps
module atm_conv_seq import atm_pkg::*; (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic [NUM_SLOTS-1:0]      en,
    input  slot_cfg_t [NUM_SLOTS-1:0] cfg,
    input  logic                      sd_busy,
    input  logic                      adc_ack,
    input  logic [RES_W-1:0]          adc_result,
    output logic                      adc_req,
    output logic [CHAN_W-1:0]         adc_chan,
    output logic [NUM_SLOTS-1:0]      trip,
    output logic                      idle
);
    conv_state_e st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CV_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            CV_IDLE: if (tick && !sd_busy) begin
                if (en[0])      nxt = CV_SLOT0;
                else if (en[1]) nxt = CV_SLOT1;
            end
            CV_SLOT0: if (adc_ack)
                nxt = (en[1] && !trip[0] && !sd_busy) ? CV_SLOT1 : CV_IDLE;
            CV_SLOT1: if (adc_ack) nxt = CV_IDLE;
            default:  nxt = CV_IDLE;
        endcase
    end

    always_comb begin
        idle     = (st == CV_IDLE);
        adc_req  = (st != CV_IDLE);
        adc_chan = (st == CV_SLOT1) ? cfg[1].chan : cfg[0].chan;
        trip[0]  = (st == CV_SLOT0) && adc_ack && crossed(adc_result, cfg[0]);
        trip[1]  = (st == CV_SLOT1) && adc_ack && crossed(adc_result, cfg[1]);
    end

    assert_hold_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_req && !adc_ack) |=> (adc_req && $stable(adc_chan)));
endmodule

// File: rtl/auto_thresh_monitor.sv
`timescale 1ns/1ps
module auto_thresh_monitor import atm_pkg::*; #(
    parameter int CLK_MHZ     = 200,
    parameter int WAIT_US     = 100,
    parameter int BASE_CYCLES = 64,
    parameter int CODE_W      = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic        adc_req,
    output logic [3:0]  adc_chan,
    input  logic        adc_ack,
    input  logic [11:0] adc_result,
    output logic        irq_slot0,
    output logic        irq_slot1,
    output logic        available
);
    localparam int WAIT_CYCLES = CLK_MHZ * WAIT_US;

    logic [NUM_SLOTS-1:0]      en, irq_clr, trip, irq_q;
    logic [CODE_W-1:0]         code;
    slot_cfg_t [NUM_SLOTS-1:0] cfg;
    logic                      stop_req, clr_en, force_on, tick, conv_idle;

    atm_cfg_regs #(.CODE_W(CODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .clr_en(clr_en), .en(en), .code(code), .cfg(cfg),
        .irq_clr(irq_clr), .stop_req(stop_req)
    );

    atm_period_timer #(.BASE_CYCLES(BASE_CYCLES), .CODE_W(CODE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(|en), .code(code), .tick(tick)
    );

    atm_shutdown_seq #(.WAIT_CYCLES(WAIT_CYCLES)) u_sd (
        .clk(clk), .rst_n(rst_n), .start(stop_req || (|trip)),
        .force_on(force_on), .clr_en(clr_en)
    );

    atm_conv_seq u_conv (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .cfg(cfg),
        .sd_busy(force_on), .adc_ack(adc_ack), .adc_result(adc_result),
        .adc_req(adc_req), .adc_chan(adc_chan), .trip(trip), .idle(conv_idle)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_irq
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q[i] <= 1'b0;
            else        irq_q[i] <= (irq_q[i] && !irq_clr[i]) || trip[i];
        end
        assert_irq_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_q[i]) |-> $past(adc_ack));
    end

    assign irq_slot0 = irq_q[0];
    assign irq_slot1 = irq_q[1];
    assign available = conv_idle && !force_on;

    assert_no_start_when_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_req) |-> $past(!force_on));
    assert_release_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(force_on) |-> (en == '0));
endmodule

// File: tb/tb_auto_thresh_monitor.sv
`timescale 1ns/1ps
module tb_auto_thresh_monitor;
    localparam int BASE  = 64;
    localparam int WAITC = 200 * 100;
    localparam int LAT   = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        adc_req;
    logic [3:0]  adc_chan;
    logic        adc_ack = 1'b0;
    logic [11:0] adc_result = '0;
    logic        irq_slot0, irq_slot1, available;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    auto_thresh_monitor dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .adc_req(adc_req), .adc_chan(adc_chan),
        .adc_ack(adc_ack), .adc_result(adc_result), .irq_slot0(irq_slot0),
        .irq_slot1(irq_slot1), .available(available)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ADC core responder: fixed latency, one-cycle acknowledge
    logic [11:0] res_tab [16];
    int conv_cnt [16];
    bit rbusy = 0;
    int rcnt = 0;
    int rchan = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            adc_ack = 1'b0;
            rbusy = 0;
        end else if (adc_ack) begin
            adc_ack = 1'b0;
            rbusy = 0;
        end else if (rbusy) begin
            rcnt--;
            if (rcnt == 0) begin
                adc_ack = 1'b1;
                adc_result = res_tab[rchan];
            end
        end
        if (rst_n && !rbusy && !adc_ack && adc_req) begin
            rbusy = 1;
            rcnt = LAT;
            rchan = int'(adc_chan);
            conv_cnt[rchan]++;
        end
    end

    // Behavioural reference model, advanced on each rising edge
    bit m_en [2];
    int m_code, m_timer, m_phase, m_sd, m_wait;
    int m_chan [2];
    int m_lim [2];
    bit m_below [2];
    bit m_irq [2];

    function automatic bit hit(input int r, input int s);
        return m_below[s] ? (r < m_lim[s]) : (r > m_lim[s]);
    endfunction

    always @(posedge clk) begin
        bit t0, t1, tk, stopw, any;
        int np, nt, nsd, nw;
        if (!rst_n) begin
            m_en[0] = 0; m_en[1] = 0; m_code = 0; m_timer = 0; m_phase = 0;
            m_sd = 0; m_wait = 0; m_chan[0] = 0; m_chan[1] = 0;
            m_lim[0] = 0; m_lim[1] = 0; m_below[0] = 0; m_below[1] = 0;
            m_irq[0] = 0; m_irq[1] = 0;
        end else begin
            any   = m_en[0] || m_en[1];
            t0    = adc_ack && m_phase == 1 && hit(int'(adc_result), 0);
            t1    = adc_ack && m_phase == 2 && hit(int'(adc_result), 1);
            stopw = cfg_we && cfg_addr == 3'd0 && cfg_wdata[2];
            tk    = any && (m_timer >= (BASE << m_code) - 1);
            np = m_phase;
            if (m_phase == 0) begin
                if (tk && m_sd == 0) np = m_en[0] ? 1 : (m_en[1] ? 2 : 0);
            end else if (m_phase == 1) begin
                if (adc_ack) np = (m_en[1] && !t0 && m_sd == 0) ? 2 : 0;
            end else if (adc_ack) begin
                np = 0;
            end
            nt = (!any || tk) ? 0 : m_timer + 1;
            nsd = m_sd; nw = m_wait;
            case (m_sd)
                0: if (t0 || t1 || stopw) nsd = 1;
                1: nsd = 2;
                2: begin nsd = 3; nw = 0; end
                default: if (m_wait == WAITC - 1) nsd = 0; else nw = m_wait + 1;
            endcase
            for (int s = 0; s < 2; s++)
                m_irq[s] = (m_irq[s] && !(cfg_we && cfg_addr == 3'd7 && cfg_wdata[s]))
                           || (s == 0 ? t0 : t1);
            if (m_sd == 2) begin
                m_en[0] = 0; m_en[1] = 0;
            end else if (cfg_we && cfg_addr == 3'd0 && !cfg_wdata[2]) begin
                m_en[0] = cfg_wdata[0]; m_en[1] = cfg_wdata[1];
            end
            if (cfg_we) begin
                case (cfg_addr)
                    3'd1: m_code = int'(cfg_wdata[3:0]);
                    3'd2: begin m_chan[0] = int'(cfg_wdata[3:0]); m_chan[1] = int'(cfg_wdata[7:4]); end
                    3'd3: m_lim[0] = (m_lim[0] & 32'hF00) | int'(cfg_wdata);
                    3'd4: begin m_lim[0] = (m_lim[0] & 32'h0FF) | (int'(cfg_wdata[3:0]) << 8); m_below[0] = cfg_wdata[7]; end
                    3'd5: m_lim[1] = (m_lim[1] & 32'hF00) | int'(cfg_wdata);
                    3'd6: begin m_lim[1] = (m_lim[1] & 32'h0FF) | (int'(cfg_wdata[3:0]) << 8); m_below[1] = cfg_wdata[7]; end
                    default: ;
                endcase
            end
            m_phase = np; m_timer = nt; m_sd = nsd; m_wait = nw;
        end
    end

    // Every-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(adc_req == (m_phase != 0), "R3 request", int'(adc_req), int'(m_phase != 0));
            if (m_phase != 0)
                chk(int'(adc_chan) == m_chan[m_phase-1], "R3 channel", int'(adc_chan), m_chan[m_phase-1]);
            chk(irq_slot0 == m_irq[0], "R6 irq_slot0", int'(irq_slot0), int'(m_irq[0]));
            chk(irq_slot1 == m_irq[1], "R6 irq_slot1", int'(irq_slot1), int'(m_irq[1]));
            chk(available == (m_phase == 0 && m_sd == 0), "R9 available",
                int'(available), int'(m_phase == 0 && m_sd == 0));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c;
        for (int k = 0; k < 16; k++) begin res_tab[k] = '0; conv_cnt[k] = 0; end
        wait_cycles(5);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_req == 0, "R1 req after reset", int'(adc_req), 0);
        chk(irq_slot0 == 0 && irq_slot1 == 0, "R1 irqs after reset", int'({irq_slot1, irq_slot0}), 0);
        chk(available == 1, "R1 available after reset", int'(available), 1);

        // Both slots, no crossings; limits via split bytes (R11)
        res_tab[2] = 12'h400; res_tab[5] = 12'h200;
        wr(3'd2, 8'h52);
        wr(3'd3, 8'h00); wr(3'd4, 8'h08);
        wr(3'd5, 8'h00); wr(3'd6, 8'h81);
        wr(3'd1, 8'h01);
        for (int k = 0; k < 16; k++) conv_cnt[k] = 0;
        wr(3'd0, 8'h03);
        wait_cycles(599);
        chk(conv_cnt[2] == 4, "R2 slot0 rounds in 600 cycles", conv_cnt[2], 4);
        chk(conv_cnt[5] == 4, "R3 slot1 rounds follow slot0", conv_cnt[5], 4);
        chk(irq_slot1 == 0, "R11 floor 0x100 not crossed by 0x200", int'(irq_slot1), 0);

        // Equal to the ceiling: no trip (R4)
        res_tab[2] = 12'h800;
        wait_cycles(140);
        chk(irq_slot0 == 0, "R4 equal result no trip", int'(irq_slot0), 0);

        // Ceiling crossed: trip, shutdown, slot1 skipped (R4, R7, R10)
        res_tab[2] = 12'h801;
        c = conv_cnt[5];
        wait_cycles(140);
        chk(irq_slot0 == 1, "R4 ceiling crossed", int'(irq_slot0), 1);
        chk(irq_slot1 == 0, "R6 other slot untouched", int'(irq_slot1), 0);
        chk(available == 0, "R7 forced during wait", int'(available), 0);
        chk(conv_cnt[5] == c, "R10 slot1 skipped after trip", conv_cnt[5], c);
        wait_cycles(WAITC + 200);
        chk(available == 1, "R7 released after wait", int'(available), 1);
        c = conv_cnt[2];
        wait_cycles(400);
        chk(conv_cnt[2] == c, "R7 no conversions after shutdown", conv_cnt[2], c);
        chk(adc_req == 0, "R7 request idle", int'(adc_req), 0);

        wr(3'd7, 8'h01);
        chk(irq_slot0 == 0, "R6 write-one clears slot0", int'(irq_slot0), 0);

        // Floor crossed on slot1 only (R5, R11)
        res_tab[5] = 12'h0FF;
        wr(3'd0, 8'h02);
        wait_cycles(300);
        chk(irq_slot1 == 1, "R5 floor crossed", int'(irq_slot1), 1);
        chk(irq_slot1 == 1, "R11 polarity bit 7 selects floor", int'(irq_slot1), 1);
        chk(irq_slot0 == 0, "R5 slot0 quiet", int'(irq_slot0), 0);
        wait_cycles(WAITC + 100);
        wr(3'd7, 8'h01);
        chk(irq_slot1 == 1, "R6 clear of bit0 leaves slot1", int'(irq_slot1), 1);
        wr(3'd7, 8'h02);
        chk(irq_slot1 == 0, "R6 write-one clears slot1", int'(irq_slot1), 0);

        // Software stop (R8)
        res_tab[2] = 12'h100; res_tab[5] = 12'h300;
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h03);
        wait_cycles(200);
        wr(3'd0, 8'h04);
        wait_cycles(10);
        chk(available == 0, "R8 stop forces engine on", int'(available), 0);
        chk(irq_slot0 == 0 && irq_slot1 == 0, "R8 stop raises no irq", int'({irq_slot1, irq_slot0}), 0);
        wait_cycles(WAITC + 100);
        chk(available == 1, "R8 released after wait", int'(available), 1);
        c = conv_cnt[2] + conv_cnt[5];
        wait_cycles(300);
        chk(conv_cnt[2] + conv_cnt[5] == c, "R8 slots disabled after stop", conv_cnt[2] + conv_cnt[5], c);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule